// File: doc/BRIEF.md
# Two-Stage Bitstream Decimation Filter

This block converts the single-bit output of a sigma-delta modulator into signed 16-bit words. The modulator delivers two bits on every master clock. A first, multiplier-free stage treats each bit as +1 or -1 and sums a sliding window of 16 bits. It produces one value every 4 clocks, so it decimates by 8. A second stage is a symmetric 15-tap FIR with triangular weights. It decimates by a further 8, and it shares one multiply-accumulate unit over eight clocks by pre-adding mirrored taps. Both stages are symmetric, so the overall phase response is linear. One word leaves the block every 32 master clocks.

A one-clock sync pulse restarts the filter. It empties both delay lines, realigns the output phase and restarts a settling timer. The settled flag marks the point from which the words again reflect only the new input. A mode bit selects either the full 16-bit word or a word rounded to 12 bits.

Top module: `dfilt_top`

## Requirements
- R1: While reset is high and on the first clock after it, data_o is 0, valid_o is 0 and settled_o is 0.
- R2: valid_o is high for exactly one clock. During uninterrupted operation, consecutive strobes are exactly 32 clocks apart.
- R3: data_o changes only in a clock in which valid_o is high, and it holds its value between strobes.
- R4: Input bit value 1 counts as +1 and 0 counts as -1, and both lanes of bits_i carry equal weight. Feed a bitstream whose every 16 consecutive bits contain k ones, in 16-bit mode. Once settled_o is high, each word equals 2048*(2k-16) in two's complement. For example, k=12 gives 0x4000, k=4 gives 0xC000 and k=8 gives 0x0000.
- R5: Results beyond the 16-bit range saturate: all ones gives 0x7FFF and all zeros gives 0x8000. No internal sum wraps around.
- R6: With mode12_i high, the word is rounded to nearest by adding 8 and shifting right by 4. The result is clipped to the range -2048..2047 and placed in bits 15:4, and bits 3:0 are zero. For example, all ones gives 0x7FF0 and k=12 gives 0x4000. mode12_i is sampled 1 clock before the strobe.
- R7: After reset or a sync pulse, settled_o stays low for SETTLE_CLKS (default 1456) clocks. It rises on the SETTLE_CLKS-th rising edge after the sync edge.
- R8: A sync pulse clears all filter history and the output phase. The next strobe comes 9 clocks after the sync edge and carries the word 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_i | input | 1 | One-clock filter restart pulse |
| mode12_i | input | 1 | High selects the 12-bit rounded word |
| bits_i | input | 2 | Two modulator bits per clock |
| data_o | output | 16 | Filtered output word, two's complement |
| valid_o | output | 1 | One-clock strobe marking a new word |
| settled_o | output | 1 | High once the filter history is fully refreshed |

## Verification
The delay lines and the accumulator are hidden, so most faults surface in the DC value of a settled word, which arrives within 32 clocks of settling. A bad lane weight or a wrong tap weight shifts the code by a multiple of 2048. A lost clear is visible in the first word after sync, 9 clocks after the sync edge, which must read 0 even after full-scale input. Phase-counter faults show up at once as a strobe gap other than 32 clocks. Settle-counter faults show up as settled_o rising one or more clocks away from 1456.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;
  localparam int OUT_W = 16;

  // Triangular weight of mirrored tap pair k (k counts from the outer end).
  function automatic int tap_weight(input int k);
    return k + 1;
  endfunction

  // Scale, saturate to 16 bits, and optionally round to 12 bits.
  function automatic logic [OUT_W-1:0] shape_word(input int acc, input logic mode12,
                                                  input int gain_sh);
    int w;
    int r;
    w = acc * (1 << gain_sh);
    if (w > 32767) w = 32767;
    if (w < -32768) w = -32768;
    if (!mode12) return OUT_W'(w);
    r = (w + 8) >>> 4;
    if (r > 2047) r = 2047;
    return {12'(r), 4'b0000};
  endfunction
endpackage

// File: rtl/dfilt_boxcar.sv
module dfilt_boxcar #(
  parameter int WIN   = 16,
  parameter int LANES = 2,
  parameter int S1_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic [LANES-1:0]       bits_i,
  output logic signed [S1_W-1:0] sum_o
);
  localparam int KEEP = WIN - LANES;

  logic [KEEP-1:0] hist_q;
  logic [WIN-1:0]  window;
  int              ones;

  assign window = {hist_q, bits_i};

  always_comb begin
    ones = 0;
    for (int i = 0; i < WIN; i++) ones += int'(window[i]);
    sum_o = S1_W'(2 * ones - WIN);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) hist_q <= '0;
    else            hist_q <= window[KEEP-1:0];
  end
endmodule

// File: rtl/dfilt_mac.sv
module dfilt_mac #(
  parameter int TAPS  = 15,
  parameter int S1_W  = 6,
  parameter int ACC_W = 16,
  parameter int PH_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    push,
  input  logic signed [S1_W-1:0]  sample,
  input  logic                    snap,
  input  logic                    mac_en,
  input  logic [PH_W-1:0]         mac_idx,
  output logic signed [ACC_W-1:0] acc_o
);
  import dfilt_pkg::*;
  localparam int HALF = (TAPS + 1) / 2;

  logic signed [S1_W-1:0]  line_q [TAPS];
  logic signed [S1_W-1:0]  line_n [TAPS];
  logic signed [S1_W-1:0]  hold_q [TAPS];
  logic signed [S1_W:0]    pair;
  logic signed [ACC_W-1:0] wt, prod;
  int                      k;

  assign line_n[0] = push ? sample : line_q[0];
  for (genvar g = 1; g < TAPS; g++) begin : g_line
    assign line_n[g] = push ? line_q[g-1] : line_q[g];
  end

  always_comb begin
    k = (int'(mac_idx) < HALF) ? int'(mac_idx) : 0;
    if ((TAPS % 2 == 1) && (k == HALF - 1))
      pair = (S1_W+1)'(hold_q[k]);
    else
      pair = (S1_W+1)'(hold_q[k]) + (S1_W+1)'(hold_q[TAPS-1-k]);
    wt   = ACC_W'(tap_weight(k));
    prod = ACC_W'(pair) * wt;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < TAPS; i++) begin
        line_q[i] <= '0;
        hold_q[i] <= '0;
      end
      acc_o <= '0;
    end else begin
      for (int i = 0; i < TAPS; i++) begin
        line_q[i] <= line_n[i];
        if (snap) hold_q[i] <= line_n[i];
      end
      if (mac_en) acc_o <= ((mac_idx == '0) ? '0 : acc_o) + prod;
    end
  end
endmodule

// File: rtl/dfilt_settle.sv
module dfilt_settle #(
  parameter int SETTLE_CLKS = 1456
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic settled_o
);
  localparam int CW = $clog2(SETTLE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CLKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)     cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign settled_o = (cnt_q == LAST);
endmodule

// File: rtl/dfilt_top.sv
module dfilt_top #(
  parameter int LANES       = 2,
  parameter int S1_WIN      = 16,
  parameter int S1_DEC      = 8,
  parameter int S2_TAPS     = 15,
  parameter int S2_DEC      = 8,
  parameter int GAIN_SH     = 5,
  parameter int SETTLE_CLKS = 1456
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sync_i,
  input  logic        mode12_i,
  input  logic [1:0]  bits_i,
  output logic [15:0] data_o,
  output logic        valid_o,
  output logic        settled_o
);
  import dfilt_pkg::*;
  localparam int S1_CLKS = S1_DEC / LANES;
  localparam int FRAME   = S1_CLKS * S2_DEC;
  localparam int PH_W    = $clog2(FRAME);
  localparam int S1_W    = $clog2(S1_WIN + 1) + 1;
  localparam int HALF    = (S2_TAPS + 1) / 2;
  localparam int ACC_LIM = S1_WIN * HALF * HALF;
  localparam int ACC_W   = $clog2(ACC_LIM + 1) + 2;

  logic [PH_W-1:0]         ph_q;
  logic signed [S1_W-1:0]  s1_sum;
  logic signed [ACC_W-1:0] acc;
  logic                    s1_push, frame_end, mac_en, fmt_now;

  assign s1_push   = (int'(ph_q) % S1_CLKS) == S1_CLKS - 1;
  assign frame_end = int'(ph_q) == FRAME - 1;
  assign mac_en    = int'(ph_q) < HALF;
  assign fmt_now   = int'(ph_q) == HALF;

  always_ff @(posedge clk) begin
    if (rst || sync_i) ph_q <= '0;
    else               ph_q <= frame_end ? '0 : ph_q + 1'b1;
  end

  dfilt_boxcar #(.WIN(S1_WIN), .LANES(LANES), .S1_W(S1_W)) u_s1 (
    .clk(clk), .rst(rst), .clr(sync_i), .bits_i(bits_i), .sum_o(s1_sum));

  dfilt_mac #(.TAPS(S2_TAPS), .S1_W(S1_W), .ACC_W(ACC_W), .PH_W(PH_W)) u_s2 (
    .clk(clk), .rst(rst), .clr(sync_i), .push(s1_push), .sample(s1_sum),
    .snap(frame_end), .mac_en(mac_en), .mac_idx(ph_q), .acc_o(acc));

  dfilt_settle #(.SETTLE_CLKS(SETTLE_CLKS)) u_settle (
    .clk(clk), .rst(rst), .clr(sync_i), .settled_o(settled_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (sync_i) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= fmt_now;
      if (fmt_now) data_o <= shape_word(int'(acc), mode12_i, GAIN_SH);
    end
  end
endmodule

// File: rtl/dfilt_chk.sv
module dfilt_chk #(
  parameter int FRAME   = 32,
  parameter int S1_WIN  = 16,
  parameter int ACC_LIM = 1024,
  parameter int S1_W    = 6,
  parameter int ACC_W   = 13
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sync_i,
  input logic                    mode12_i,
  input logic                    valid_o,
  input logic [15:0]             data_o,
  input logic                    settled_o,
  input logic signed [S1_W-1:0]  s1_sum,
  input logic signed [ACC_W-1:0] acc
);
  int gap_q;
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst || sync_i) begin
      seen_q <= 1'b0;
      gap_q  <= 0;
    end else if (valid_o) begin
      seen_q <= 1'b1;
      gap_q  <= 0;
    end else begin
      gap_q  <= gap_q + 1;
    end
  end

  assert_one_clock_R2: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  assert_period_R2: assert property (@(posedge clk) disable iff (rst)
    (valid_o && seen_q && !sync_i) |-> (gap_q == FRAME - 1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(data_o));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (int'(s1_sum) <= S1_WIN) && (int'(s1_sum) >= -S1_WIN) &&
    (int'(acc) <= ACC_LIM) && (int'(acc) >= -ACC_LIM));
  assert_low_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(mode12_i)) |-> (data_o[3:0] == 4'b0000));
  assert_settle_clear_R7: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> !settled_o);
endmodule

bind dfilt_top dfilt_chk #(.FRAME(FRAME), .S1_WIN(S1_WIN), .ACC_LIM(ACC_LIM),
                           .S1_W(S1_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .sync_i(sync_i), .mode12_i(mode12_i), .valid_o(valid_o),
  .data_o(data_o), .settled_o(settled_o), .s1_sum(s1_sum), .acc(acc));

// File: tb/dfilt_top_tb_top.sv
`timescale 1ns/1ps
module dfilt_top_tb_top;
  localparam int SETTLE = 1456;
  localparam int NV = 11;
  // {mode12, 16-bit repeating pattern, expected word}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'hFFFF, 16'h7FFF}, {1'b0, 16'h0000, 16'h8000},
    {1'b0, 16'hAAAA, 16'h0000}, {1'b0, 16'h7777, 16'h4000},
    {1'b0, 16'h1111, 16'hC000}, {1'b0, 16'hFFFE, 16'h7000},
    {1'b0, 16'h0001, 16'h9000}, {1'b1, 16'hFFFF, 16'h7FF0},
    {1'b1, 16'h0000, 16'h8000}, {1'b1, 16'h7777, 16'h4000},
    {1'b1, 16'h0001, 16'h9000}};

  logic clk = 0, rst = 1, sync_i = 0, mode12_i = 0;
  logic [1:0] bits_i = '0;
  logic [15:0] data_o, pat = 16'hAAAA;
  logic valid_o, settled_o;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dfilt_top dut_i (.clk(clk), .rst(rst), .sync_i(sync_i), .mode12_i(mode12_i),
    .bits_i(bits_i), .data_o(data_o), .valid_o(valid_o), .settled_o(settled_o));

  initial begin
    int idx = 0;
    forever begin
      @(negedge clk);
      bits_i = pat[2*idx +: 2];
      idx = (idx + 1) % 8;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic pulse_sync();
    @(negedge clk) sync_i = 1;
    @(negedge clk) sync_i = 0;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!valid_o && n < 100);
  endtask

  task automatic wait_settled();
    int n = 0;
    while (!settled_o && n < SETTLE + 10) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] held;
    bit stable;
    string tag;
    repeat (4) @(negedge clk);
    chk(data_o == 0 && !valid_o && !settled_o, "R1 in reset",
        {data_o[15:2], valid_o, settled_o}, 16'h0);
    rst = 0;
    @(negedge clk);
    chk(data_o == 0 && !valid_o && !settled_o, "R1 after reset",
        {data_o[15:2], valid_o, settled_o}, 16'h0);

    // settle timing after sync (R7)
    pulse_sync();
    repeat (SETTLE - 1) @(negedge clk);
    chk(!settled_o, "R7 low before limit", 16'(settled_o), 16'h0);
    @(negedge clk);
    chk(settled_o, "R7 high at limit", 16'(settled_o), 16'h1);

    for (int v = 0; v < NV; v++) begin
      mode12_i = VEC[v][32];
      pat      = VEC[v][31:16];
      tag = VEC[v][32] ? "R6" : ((VEC[v][15:0] == 16'h7FFF || VEC[v][15:0] == 16'h8000)
            ? "R5" : "R4");
      pulse_sync();
      wait_settled();
      wait_valid(n);
      chk(data_o == VEC[v][15:0], tag, data_o, VEC[v][15:0]);
      held = data_o;
      @(negedge clk);
      chk(!valid_o, "R2 single-clock strobe", 16'(valid_o), 16'h0);
      stable = 1;
      n = 1;
      while (!valid_o && n < 100) begin
        if (data_o != held) stable = 0;
        @(negedge clk); n++;
      end
      chk(stable, "R3 word held between strobes", data_o, held);
      chk(n == 32, "R2 strobe period", 16'(n), 16'd32);
      chk(data_o == VEC[v][15:0], tag, data_o, VEC[v][15:0]);
    end

    // sync clears history (R8)
    mode12_i = 0;
    pat = 16'hFFFF;
    pulse_sync();
    wait_settled();
    wait_valid(n);
    chk(data_o == 16'h7FFF, "R8 preload full scale", data_o, 16'h7FFF);
    pulse_sync();
    wait_valid(n);
    chk(n == 9, "R8 first strobe delay", 16'(n), 16'd9);
    chk(data_o == 16'h0000, "R8 cleared history", data_o, 16'h0000);

    done = 1;
    summary();
    $finish;
  end
endmodule